// File: doc/BRIEF.md
# Interrupt Event Notification Router

The router accepts one event trigger at a time. Each trigger names an event descriptor by block and index and carries a data word. The router looks up the descriptor in an internal table. It filters the event through the descriptor's notification coalescing state and checks the target virtual processor in a second internal table. It then asks an external presenter whether a dispatched hardware thread takes the event at the descriptor's priority. When no thread takes it, the router can record the priority as backlog in the processor entry. The router can also escalate: it passes the event through a second coalescing stage and re-enters the flow on another descriptor that the first one names.

Both tables are loaded and inspected through plain write and read ports. The presenter is reached through a request that stays up until it is acknowledged. Each event ends with a one-cycle completion pulse that carries a result code. Only the block whose number equals the `LOCAL_BLK` parameter is held locally, so any other block number counts as a lookup miss.

Top module: `evt_notify_router`

## Requirements
- R1: `in_ready` is high only when the router is idle. It drops in the cycle after a trigger is accepted and stays low until `evt_done` has pulsed for exactly one cycle. It is high again in the cycle after that pulse.
- R2: Coalescing state is a 2-bit field, with bit 1 meaning pending and bit 0 meaning queued. A trigger moves 00 to 10 and continues. It moves 01, 10 or 11 to 11 and stops. The new value is written back into the descriptor.
- R3: A trigger or escalation whose block differs from `LOCAL_BLK` ends with code 1. One that names an invalid descriptor ends with code 2. Neither case issues a presenter request.
- R4: When the descriptor's always-notify flag is set, the notification state is neither consulted nor changed.
- R5: After notification coalescing passes, a target processor block other than `LOCAL_BLK` ends the event with code 3, and an invalid processor entry ends it with code 4.
- R6: `prs_req` holds its block, index, format, priority and data stable until `prs_ack`. When `prs_hit` is high with the acknowledge, the event ends with code 0 and nothing else changes.
- R7: On a presenter miss with backlog enabled and format 0, the router sets bit `prio` of the processor entry's 8-bit pending field. With format 1 the event ends with code 5, and the entry is left unchanged and nothing escalates.
- R8: A silent descriptor skips notification and backlog. It issues no request, leaves its notification state alone and goes straight to escalation.
- R9: Escalation occurs only when the escalate flag is set. Unless unconditional escalation is set, the escalation state must pass the R2 rule, and the updated state is written back.
- R10: Escalation restarts the flow on the descriptor named by the escalation block and index, using the escalation data as the new event data.
- R11: An event may escalate at most `MAX_DEPTH` times. A further escalation ends it with code 6.
- R12: Result codes: 0 means finished normally, including when coalescing stops the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Trigger valid |
| in_ready | output | 1 | Router idle, trigger accepted |
| in_blk | input | 4 | Descriptor block of trigger |
| in_idx | input | 4 | Descriptor index of trigger |
| in_data | input | 32 | Event data |
| dcfg_we | input | 1 | Descriptor table write enable |
| dcfg_idx | input | 4 | Descriptor write index |
| dcfg_wdata | input | 61 | Descriptor write value |
| drd_idx | input | 4 | Descriptor read index |
| drd_data | output | 61 | Descriptor read value |
| vcfg_we | input | 1 | Processor table write enable |
| vcfg_idx | input | 3 | Processor write index |
| vcfg_wdata | input | 9 | Processor write value (valid, pending byte) |
| vrd_idx | input | 3 | Processor read index |
| vrd_data | output | 9 | Processor read value |
| prs_req | output | 1 | Presenter match request |
| prs_blk | output | 4 | Requested processor block |
| prs_idx | output | 3 | Requested processor index |
| prs_fmt | output | 1 | Descriptor format (0 specific, 1 logical server) |
| prs_prio | output | 3 | Event priority |
| prs_data | output | 32 | Current event data |
| prs_ack | input | 1 | Presenter response valid |
| prs_hit | input | 1 | A dispatched thread accepted |
| evt_done | output | 1 | One-cycle completion pulse |
| evt_code | output | 3 | Result code, valid with `evt_done` |

## Verification
The assertions check the handshakes on every cycle: `in_ready` drops after acceptance and the completion pulse lasts one cycle. A presenter request stays stable until it is acknowledged. A missed or silent descriptor never leads into a request, and the escalation depth never passes its bound. The bench's scenarios are the only place where the stored effects appear: the coalescing transitions written back into descriptors, pending bits set by backlog, and the order and data of requests along an escalation chain. The same holds for result codes and for the depth-limit abort on a self-escalating descriptor.

// File: rtl/enr_pkg.sv
package enr_pkg;
    localparam int BLK_W  = 4;
    localparam int DIDX_W = 4;
    localparam int VIDX_W = 3;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 3;
    localparam int PEND_W = 1 << PRIO_W;

    typedef struct packed {
        logic              valid;
        logic              silent;
        logic              always_ntf;
        logic              backlog;
        logic              escalate;
        logic              uncond;
        logic              fmt;
        logic [PRIO_W-1:0] prio;
        logic [1:0]        pq_n;
        logic [1:0]        pq_e;
        logic [BLK_W-1:0]  vp_blk;
        logic [VIDX_W-1:0] vp_idx;
        logic [BLK_W-1:0]  esc_blk;
        logic [DIDX_W-1:0] esc_idx;
        logic [DATA_W-1:0] esc_data;
    } desc_t;

    typedef struct packed {
        logic              valid;
        logic [PEND_W-1:0] pend;
    } vp_t;

    localparam int DESC_W = $bits(desc_t);
    localparam int VP_W   = $bits(vp_t);

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_DESC_MISS = 3'd1,
        ERR_DESC_OFF  = 3'd2,
        ERR_VP_MISS   = 3'd3,
        ERR_VP_OFF    = 3'd4,
        ERR_BAD_CFG   = 3'd5,
        ERR_TOO_DEEP  = 3'd6
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EVAL, ST_PRES, ST_ESC, ST_FIN
    } st_e;
endpackage

// File: rtl/enr_pq_step.sv
module enr_pq_step (
    input  logic [1:0] pq_in,
    output logic [1:0] pq_out,
    output logic       fire
);
    always_comb begin
        fire   = (pq_in == 2'b00);
        pq_out = fire ? 2'b10 : 2'b11;
    end
endmodule

// File: rtl/enr_regfile.sv
module enr_regfile #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [W-1:0]  wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [W-1:0]  wd_b,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_d, ent_q;
        always_comb begin
            ent_d = ent_q;
            if (we_b && wa_b == AW'(g)) ent_d = wd_b;
            if (we_a && wa_a == AW'(g)) ent_d = wd_a;   // engine wins
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end
        assign view[g] = ent_q;
    end

    assign rd_a = view[ra_a];
    assign rd_b = view[ra_b];
endmodule

// File: rtl/evt_notify_router.sv
module evt_notify_router
    import enr_pkg::*;
#(
    parameter logic [BLK_W-1:0] LOCAL_BLK = 4'h2,
    parameter int               MAX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [DIDX_W-1:0] in_idx,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dcfg_we,
    input  logic [DIDX_W-1:0] dcfg_idx,
    input  logic [DESC_W-1:0] dcfg_wdata,
    input  logic [DIDX_W-1:0] drd_idx,
    output logic [DESC_W-1:0] drd_data,
    input  logic              vcfg_we,
    input  logic [VIDX_W-1:0] vcfg_idx,
    input  logic [VP_W-1:0]   vcfg_wdata,
    input  logic [VIDX_W-1:0] vrd_idx,
    output logic [VP_W-1:0]   vrd_data,
    output logic              prs_req,
    output logic [BLK_W-1:0]  prs_blk,
    output logic [VIDX_W-1:0] prs_idx,
    output logic              prs_fmt,
    output logic [PRIO_W-1:0] prs_prio,
    output logic [DATA_W-1:0] prs_data,
    input  logic              prs_ack,
    input  logic              prs_hit,
    output logic              evt_done,
    output logic [2:0]        evt_code
);
    localparam int NUM_DESC = 1 << DIDX_W;
    localparam int NUM_VP   = 1 << VIDX_W;
    localparam int DEP_W    = $clog2(MAX_DEPTH + 1);

    typedef struct packed {
        st_e               st;
        logic [BLK_W-1:0]  blk;
        logic [DIDX_W-1:0] idx;
        logic [DATA_W-1:0] data;
        logic [DEP_W-1:0]  depth;
        err_e              code;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    desc_t cur, d_wd;
    vp_t   vcur, v_wd;
    logic  d_we, v_we;
    logic [DESC_W-1:0] d_rd;
    logic [VP_W-1:0]   v_rd;
    logic [1:0] pqn_nx, pqe_nx;
    logic       fire_n, fire_e, pass_n, pass_e;

    enr_regfile #(.W(DESC_W), .DEPTH(NUM_DESC)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .we_a(d_we), .wa_a(ctl_q.idx), .wd_a(d_wd),
        .we_b(dcfg_we), .wa_b(dcfg_idx), .wd_b(dcfg_wdata),
        .ra_a(ctl_q.idx), .rd_a(d_rd),
        .ra_b(drd_idx), .rd_b(drd_data)
    );

    enr_regfile #(.W(VP_W), .DEPTH(NUM_VP)) u_vp (
        .clk(clk), .rst_n(rst_n),
        .we_a(v_we), .wa_a(cur.vp_idx), .wd_a(v_wd),
        .we_b(vcfg_we), .wa_b(vcfg_idx), .wd_b(vcfg_wdata),
        .ra_a(cur.vp_idx), .rd_a(v_rd),
        .ra_b(vrd_idx), .rd_b(vrd_data)
    );

    assign cur  = d_rd;
    assign vcur = v_rd;

    enr_pq_step u_pqn (.pq_in(cur.pq_n), .pq_out(pqn_nx), .fire(fire_n));
    enr_pq_step u_pqe (.pq_in(cur.pq_e), .pq_out(pqe_nx), .fire(fire_e));

    assign pass_n = cur.always_ntf | fire_n;
    assign pass_e = cur.uncond | fire_e;

    always_comb begin
        ctl_d     = ctl_q;
        d_we      = 1'b0;
        d_wd      = cur;
        v_we      = 1'b0;
        v_wd      = vcur;
        v_wd.pend = vcur.pend | (PEND_W'(1) << cur.prio);
        case (ctl_q.st)
            ST_IDLE: if (in_valid) begin
                ctl_d.st    = ST_EVAL;
                ctl_d.blk   = in_blk;
                ctl_d.idx   = in_idx;
                ctl_d.data  = in_data;
                ctl_d.depth = '0;
                ctl_d.code  = ERR_NONE;
            end
            ST_EVAL: begin
                if (ctl_q.blk != LOCAL_BLK) begin
                    ctl_d.code = ERR_DESC_MISS;
                    ctl_d.st   = ST_FIN;
                end else if (!cur.valid) begin
                    ctl_d.code = ERR_DESC_OFF;
                    ctl_d.st   = ST_FIN;
                end else if (cur.silent) begin
                    ctl_d.st = ST_ESC;
                end else begin
                    if (!cur.always_ntf && pqn_nx != cur.pq_n) begin
                        d_we      = 1'b1;
                        d_wd.pq_n = pqn_nx;
                    end
                    if (!pass_n) begin
                        ctl_d.st = ST_FIN;
                    end else if (cur.vp_blk != LOCAL_BLK) begin
                        ctl_d.code = ERR_VP_MISS;
                        ctl_d.st   = ST_FIN;
                    end else if (!vcur.valid) begin
                        ctl_d.code = ERR_VP_OFF;
                        ctl_d.st   = ST_FIN;
                    end else begin
                        ctl_d.st = ST_PRES;
                    end
                end
            end
            ST_PRES: if (prs_ack) begin
                if (prs_hit) begin
                    ctl_d.st = ST_FIN;
                end else if (cur.backlog && cur.fmt) begin
                    ctl_d.code = ERR_BAD_CFG;
                    ctl_d.st   = ST_FIN;
                end else begin
                    v_we     = cur.backlog;
                    ctl_d.st = ST_ESC;
                end
            end
            ST_ESC: begin
                if (!cur.escalate) begin
                    ctl_d.st = ST_FIN;
                end else begin
                    if (!cur.uncond && pqe_nx != cur.pq_e) begin
                        d_we      = 1'b1;
                        d_wd.pq_e = pqe_nx;
                    end
                    if (!pass_e) begin
                        ctl_d.st = ST_FIN;
                    end else if (ctl_q.depth == DEP_W'(MAX_DEPTH)) begin
                        ctl_d.code = ERR_TOO_DEEP;
                        ctl_d.st   = ST_FIN;
                    end else begin
                        ctl_d.blk   = cur.esc_blk;
                        ctl_d.idx   = cur.esc_idx;
                        ctl_d.data  = cur.esc_data;
                        ctl_d.depth = ctl_q.depth + 1'b1;
                        ctl_d.st    = ST_EVAL;
                    end
                end
            end
            ST_FIN:  ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.code <= ERR_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = (ctl_q.st == ST_IDLE);
    assign evt_done = (ctl_q.st == ST_FIN);
    assign evt_code = ctl_q.code;
    assign prs_req  = (ctl_q.st == ST_PRES);
    assign prs_blk  = cur.vp_blk;
    assign prs_idx  = cur.vp_idx;
    assign prs_fmt  = cur.fmt;
    assign prs_prio = cur.prio;
    assign prs_data = ctl_q.data;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready) else $error("busy");          // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done && in_ready) else $error("done pulse");   // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        prs_req && !prs_ack |=> prs_req && $stable(prs_prio) && $stable(prs_idx)
            && $stable(prs_data) && $stable(prs_fmt)) else $error("hold"); // R6
    AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EVAL && (ctl_q.blk != LOCAL_BLK || !cur.valid)) |=> !prs_req)
        else $error("miss req");                                          // R3
    AST_SILENT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EVAL && cur.valid && cur.silent) |=> !prs_req)
        else $error("silent req");                                        // R8
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.depth <= DEP_W'(MAX_DEPTH)) else $error("depth");         // R11
endmodule

// File: tb/sim_evt_notify_router.sv
module sim_evt_notify_router;
    import enr_pkg::*;
    localparam logic [3:0] LB = 4'h2;
    localparam int MAXD = 4;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic in_valid = 0, in_ready;
    logic [3:0] in_blk = 0, in_idx = 0;
    logic [31:0] in_data = 0;
    logic dcfg_we = 0; logic [3:0] dcfg_idx = 0; logic [DESC_W-1:0] dcfg_wdata = 0;
    logic [3:0] drd_idx = 0; logic [DESC_W-1:0] drd_data;
    logic vcfg_we = 0; logic [2:0] vcfg_idx = 0; logic [VP_W-1:0] vcfg_wdata = 0;
    logic [2:0] vrd_idx = 0; logic [VP_W-1:0] vrd_data;
    logic prs_req, prs_fmt, prs_ack = 0, prs_hit = 0, evt_done;
    logic [3:0] prs_blk; logic [2:0] prs_idx, prs_prio, evt_code;
    logic [31:0] prs_data;

    evt_notify_router #(.LOCAL_BLK(LB), .MAX_DEPTH(MAXD)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    desc_t md [16];
    vp_t   mv [8];
    logic [2:0] ex_idx [16]; logic [2:0] ex_prio [16];
    logic ex_fmt [16]; logic [31:0] ex_data [16];
    logic [2:0] last_code; int last_got; bit slow = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] pq_rule(input logic [1:0] p);
        return (p == 2'b00) ? 3'b110 : 3'b011;   // {notify, next}
    endfunction

    task automatic put_desc(input int i, input desc_t d);
        @(negedge clk); dcfg_we = 1; dcfg_idx = 4'(i); dcfg_wdata = d; md[i] = d;
        @(negedge clk); dcfg_we = 0;
    endtask

    task automatic put_vp(input int i, input vp_t v);
        @(negedge clk); vcfg_we = 1; vcfg_idx = 3'(i); vcfg_wdata = v; mv[i] = v;
        @(negedge clk); vcfg_we = 0;
    endtask

    task automatic model(input logic [3:0] b0, input logic [3:0] i0, input logic [31:0] d0,
                         input logic [31:0] mask, output logic [2:0] code, output int nreq);
        logic [3:0] cb, ci; logic [31:0] cd; int depth; bit fin, esc_go, pass;
        desc_t d; logic [2:0] r;
        code = 0; nreq = 0; cb = b0; ci = i0; cd = d0; depth = 0; fin = 0;
        for (int s = 0; s < 40 && !fin; s++) begin
            esc_go = 0;
            if (cb != LB) begin code = 1; fin = 1; end
            else if (!md[ci].valid) begin code = 2; fin = 1; end
            else if (md[ci].silent) esc_go = 1;
            else begin
                d = md[ci]; pass = 1;
                if (!d.always_ntf) begin r = pq_rule(d.pq_n); md[ci].pq_n = r[1:0]; pass = r[2]; end
                if (!pass) fin = 1;
                else if (d.vp_blk != LB) begin code = 3; fin = 1; end
                else if (!mv[d.vp_idx].valid) begin code = 4; fin = 1; end
                else begin
                    ex_idx[nreq] = d.vp_idx; ex_prio[nreq] = d.prio;
                    ex_fmt[nreq] = d.fmt; ex_data[nreq] = cd;
                    if (mask[nreq]) fin = 1;
                    else if (d.backlog) begin
                        if (d.fmt) begin code = 5; fin = 1; end
                        else mv[d.vp_idx].pend[d.prio] = 1'b1;
                    end
                    nreq++;
                    if (!fin) esc_go = 1;
                end
            end
            if (esc_go) begin
                d = md[ci];
                if (!d.escalate) fin = 1;
                else begin
                    pass = 1;
                    if (!d.uncond) begin r = pq_rule(d.pq_e); md[ci].pq_e = r[1:0]; pass = r[2]; end
                    if (!pass) fin = 1;
                    else if (depth == MAXD) begin code = 6; fin = 1; end
                    else begin depth++; cb = d.esc_blk; ci = d.esc_idx; cd = d.esc_data; end
                end
            end
        end
    endtask

    task automatic cmp_tables(input string req);
        bit bad = 0;
        for (int i = 0; i < 16; i++) begin drd_idx = 4'(i); #0.1; if (drd_data !== md[i]) bad = 1; end
        for (int i = 0; i < 8; i++)  begin vrd_idx = 3'(i); #0.1; if (vrd_data !== mv[i]) bad = 1; end
        chk(!bad, req, "table contents", bad, 0);
    endtask

    task automatic run_event(input logic [3:0] b, input logic [3:0] i, input logic [31:0] dt,
                             input logic [31:0] mask, input string req);
        logic [2:0] mcode; int mn, got, cyc; bit held, badreq;
        model(b, i, dt, mask, mcode, mn);
        @(negedge clk); in_valid = 1; in_blk = b; in_idx = i; in_data = dt;
        chk(in_ready === 1'b1, "R1", "ready when idle", in_ready, 1);
        @(negedge clk); in_valid = 0;
        chk(in_ready === 1'b0, "R1", "busy after accept", in_ready, 0);
        got = 0; cyc = 0; held = 0; badreq = 0;
        while (evt_done !== 1'b1 && cyc < 200) begin
            if (prs_req === 1'b1) begin
                if (got >= mn || prs_idx !== ex_idx[got] || prs_prio !== ex_prio[got] ||
                    prs_fmt !== ex_fmt[got] || prs_data !== ex_data[got] || prs_blk !== LB)
                    badreq = 1;
                if (slow && !held) held = 1;
                else begin prs_ack = 1; prs_hit = mask[got]; got++; held = 0; end
            end
            @(negedge clk); prs_ack = 0; prs_hit = 0; cyc++;
        end
        chk(evt_done === 1'b1, req, "completion", evt_done, 1);
        chk(evt_code === mcode, req, "result code", evt_code, mcode);
        chk(got == mn && !badreq, req, "presenter requests", got, mn);
        last_code = evt_code; last_got = got;
        @(negedge clk);
        chk(in_ready === 1'b1 && evt_done === 1'b0, "R1", "idle after done", in_ready, 1);
        cmp_tables(req);
    endtask

    task automatic rd_desc(input int i, output desc_t d);
        drd_idx = 4'(i); #0.1; d = drd_data;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        desc_t t, rb; vp_t v; logic [3:0] rb_i, ri; logic [31:0] rd_;
        void'($urandom(32'd7321));
        for (int i = 0; i < 16; i++) md[i] = '0;
        for (int i = 0; i < 8; i++)  mv[i] = '0;
        #20 rst_n = 1;
        @(negedge clk);
        chk(in_ready === 1'b1 && evt_done === 1'b0 && prs_req === 1'b0, "R1", "reset outputs",
            {in_ready, evt_done, prs_req}, 3'b100);
        cmp_tables("R1");

        v = '0; v.valid = 1; put_vp(0, v);
        t = '0; t.valid = 1; t.prio = 3; t.vp_blk = LB; t.vp_idx = 0; put_desc(1, t);
        // R2: 00 -> 10 with a request, then 10 -> 11 with none
        run_event(LB, 1, 32'hA1, 32'h1, "R2");
        rd_desc(1, rb); chk(rb.pq_n == 2'b10 && last_got == 1, "R2", "00 to 10", rb.pq_n, 2'b10);
        run_event(LB, 1, 32'hA2, 32'h1, "R2");
        rd_desc(1, rb); chk(rb.pq_n == 2'b11 && last_got == 0, "R2", "10 to 11", rb.pq_n, 2'b11);
        t.pq_n = 2'b01; put_desc(1, t);
        run_event(LB, 1, 32'hA3, 32'h1, "R2");
        rd_desc(1, rb); chk(rb.pq_n == 2'b11 && last_got == 0, "R2", "01 to 11", rb.pq_n, 2'b11);
        // R3: miss and invalid descriptor
        run_event(LB ^ 4'h1, 1, 32'hB0, 32'h1, "R3");
        chk(last_code == 3'd1, "R3", "block miss code", last_code, 1);
        run_event(LB, 9, 32'hB1, 32'h1, "R3");
        chk(last_code == 3'd2, "R3", "invalid code", last_code, 2);
        // R4: always-notify bypasses the state
        t.always_ntf = 1; t.pq_n = 2'b11; put_desc(1, t);
        run_event(LB, 1, 32'hC0, 32'h1, "R4");
        rd_desc(1, rb); chk(rb.pq_n == 2'b11 && last_got == 1, "R4", "bypass", last_got, 1);
        // R5: processor checks
        t.vp_idx = 1; put_desc(1, t);
        run_event(LB, 1, 32'hD0, 32'h1, "R5");
        chk(last_code == 3'd4, "R5", "vp invalid code", last_code, 4);
        t.vp_idx = 0; t.vp_blk = LB ^ 4'h4; put_desc(1, t);
        run_event(LB, 1, 32'hD1, 32'h1, "R5");
        chk(last_code == 3'd3, "R5", "vp miss code", last_code, 3);
        // R6/R7: slow acknowledge, hit, backlog
        t.vp_blk = LB; t.backlog = 1; t.prio = 5; put_desc(1, t); slow = 1;
        run_event(LB, 1, 32'hE0, 32'h1, "R6");
        vrd_idx = 0; #0.1; chk(vrd_data == 9'h100, "R6", "hit leaves entry", vrd_data, 9'h100);
        run_event(LB, 1, 32'hE1, 32'h0, "R7");
        vrd_idx = 0; #0.1; chk(vrd_data == 9'h120, "R7", "backlog bit 5", vrd_data, 9'h120);
        t.fmt = 1; t.prio = 2; put_desc(1, t);
        run_event(LB, 1, 32'hE2, 32'h0, "R7");
        vrd_idx = 0; #0.1;
        chk(last_code == 3'd5 && vrd_data == 9'h120, "R7", "format 1 backlog", last_code, 5);
        slow = 0;
        // R8/R10: silent escalation into descriptor 3
        t = '0; t.valid = 1; t.always_ntf = 1; t.vp_blk = LB; t.prio = 1; put_desc(3, t);
        t = '0; t.valid = 1; t.silent = 1; t.escalate = 1; t.uncond = 1;
        t.esc_blk = LB; t.esc_idx = 3; t.esc_data = 32'hBEEF; put_desc(2, t);
        run_event(LB, 2, 32'h55, 32'h1, "R8");
        rd_desc(2, rb); chk(rb.pq_n == 2'b00 && last_got == 1, "R8", "silent skip", rb.pq_n, 0);
        chk(ex_data[0] == 32'hBEEF, "R10", "escalation data", ex_data[0], 32'hBEEF);
        // R9: gated escalation
        t = '0; t.valid = 1; t.always_ntf = 1; t.vp_blk = LB; t.escalate = 1;
        t.esc_blk = LB; t.esc_idx = 3; t.esc_data = 32'h77; put_desc(4, t);
        run_event(LB, 4, 32'h66, 32'h2, "R9");
        rd_desc(4, rb); chk(rb.pq_e == 2'b10 && last_got == 2, "R9", "escalation fires", last_got, 2);
        run_event(LB, 4, 32'h67, 32'h0, "R9");
        rd_desc(4, rb); chk(rb.pq_e == 2'b11 && last_got == 1, "R9", "escalation coalesced", last_got, 1);
        // R11: self-escalating loop
        t = '0; t.valid = 1; t.silent = 1; t.escalate = 1; t.uncond = 1;
        t.esc_blk = LB; t.esc_idx = 6; put_desc(6, t);
        run_event(LB, 6, 32'h0, 32'h0, "R11");
        chk(last_code == 3'd6, "R11", "depth abort", last_code, 6);

        // randomized phase
        for (int i = 2; i < 8; i++) begin
            v.valid = ($urandom % 8) != 0; v.pend = 8'($urandom); put_vp(i, v);
        end
        for (int k = 0; k < 150; k++) begin
            if (k % 10 == 0)
                for (int j = 0; j < 4; j++) begin
                    ri = 4'($urandom);
                    t = desc_t'({$urandom, $urandom});
                    t.valid = ($urandom % 8) != 0;
                    t.vp_blk = ($urandom % 8 == 0) ? LB ^ 4'h1 : LB;
                    t.esc_blk = ($urandom % 8 == 0) ? LB ^ 4'h2 : LB;
                    put_desc(int'(ri), t);
                end
            slow = $urandom % 2;
            rb_i = 4'($urandom); rd_ = $urandom;
            run_event(($urandom % 8 == 0) ? LB ^ 4'h8 : LB, rb_i, rd_, $urandom, "R12");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule